// File: doc/BRIEF.md
# Calibration Trigger Cell Sequencer

This block decides, for every calibration trigger request, which analog storage cell is used and on which of the two storage chips (upper or lower) it lies. It also emits a delayed trigger strobe and a separately delayed pulser strobe, so that the pulser can fire early, on time or late with respect to the trigger. A single 16-bit setup word, loaded through a plain write port, selects the targeting scheme and the pulser skew.

The setup word offers fixed cells reached through a non-linear code table that spills onto the opposite chip, stepping through cells on one chip, a full scan that walks both chips, and a mode that pins the second-level cell while the first-level cell is fixed or stepped with a pseudo-random chip choice. Several code ranges turn the triggers off. Requests arrive as one-cycle strobes and must be at least 8 cycles apart. The trigger strobe always lags the request by 3 cycles, and the pulser strobe lands anywhere from 0 to 7 cycles after it.

Setup word layout: bits 5:0 cell code, bit 6 chip choice (0 upper, 1 lower), bit 7 scan enable, bits 10:8 pulser skew, bit 12 second-level fixed mode. Bits 11 and 15:13 are stored nowhere and have no effect.

Top module: `cal_cell_sequencer`

## Requirements
- R1: After reset, l1_cell, l1_chip, l2_cell, cell_valid, trig_strobe and pulse_strobe are all 0, and the setup word behaves as 0x00F0 (full scan starting at cell 5 on the upper chip).
- R2: With bits 12 and 7 clear, a code c from 0 to 38 gives cell c+8 on the chip named by bit 6, and a code from 39 to 41 gives cell c-34 (cells 5 to 7) on the other chip. cell_valid is 1 and l2_cell is 0.
- R3: With bits 12 and 7 clear, codes 42 to 47 disable the request: cell_valid, l1_cell, l1_chip and l2_cell become 0 and neither strobe fires.
- R4: With bits 12 and 7 clear, codes 48 to 63 step through cells 5, 6, ... 46, 5, ... on the chip named by bit 6, one cell per accepted request. Any setup write sends the next stepped cell back to 5.
- R5: With bit 7 set, bit 6 clear and bit 12 clear, codes 0 to 41 give the R2 cell, and the R2 chip is inverted on every second accepted request, starting uninverted after a setup write. Codes 42 to 63 disable the request.
- R6: With bits 7 and 6 set and bit 12 clear, the code is ignored. Cells step 5 to 46 on the upper chip (l1_chip 0), then 5 to 46 on the lower chip, and so on. A setup write restarts at cell 5 on the upper chip.
- R7: With bit 12 set, codes 1 to 46 set l2_cell to the code, and codes 0 and 47 to 63 disable the request. With bit 7 clear, the L1 cell is 5 on the chip named by bit 6.
- R8: With bits 12 and 7 set and a valid code, the L1 cell steps as in R4. l1_chip is bit 0 of a 16-bit register that holds 0xACE1 after reset. On each such request the register shifts left, taking in bit15^bit13^bit12^bit10. A setup write does not touch the register.
- R9: The outputs l1_cell, l1_chip, l2_cell and cell_valid change only in the cycle after the clock edge that samples trig_req high, and they hold between requests.
- R10: An accepted request sampled at edge n drives trig_strobe high for exactly the cycle after edge n+3.
- R11: An accepted request sampled at edge n drives pulse_strobe high for exactly the cycle after edge n+p. The skew field (bits 10:8) gives p as follows: 0→3, 1→2, 2→1, 3→0, 4→5, 5→6, 6→7, 7→4.
- R12: A disabled request fires neither strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup word write enable |
| cfg_wdata | input | 16 | Setup word write data |
| trig_req | input | 1 | One-cycle calibration trigger request |
| l1_cell | output | 6 | Selected first-level cell, 0 when disabled |
| l1_chip | output | 1 | Selected chip, 0 upper, 1 lower |
| l2_cell | output | 6 | Pinned second-level cell, 0 when not in fixed-L2 mode |
| cell_valid | output | 1 | Last request was accepted |
| trig_strobe | output | 1 | Delayed trigger strobe |
| pulse_strobe | output | 1 | Skewed pulser strobe |

## Verification
The hardest states to reach are the wrap points of the stepping counter: the jump from cell 46 back to 5, and the chip change that comes with it in full scan. They lie 42 accepted requests deep, and a setup write clears them. The bench writes the word once and then issues 90 or more back-to-back requests without a write, which crosses each wrap at least twice. A separate run writes again partway through a sequence to prove the restart. The pseudo-random chip sequence is followed for 60 requests against a register model kept in the bench. Every code in every mode and all eight skews are swept, and each strobe's arrival cycle is measured.

// File: rtl/cal_cell_pkg.sv
package cal_cell_pkg;

  // Stored part of the setup word (bits 11 and 15:13 carry nothing).
  typedef struct packed {
    logic       l2_fix;   // word bit 12
    logic [2:0] skew;     // word bits 10:8
    logic       scan;     // word bit 7
    logic       chip;     // word bit 6
    logic [5:0] code;     // word bits 5:0
  } cal_cfg_t;

  localparam int unsigned RND_W = 16;

  function automatic cal_cfg_t unpack_word(input logic [15:0] w);
    cal_cfg_t c;
    c.l2_fix = w[12];
    c.skew   = w[10:8];
    c.scan   = w[7];
    c.chip   = w[6];
    c.code   = w[5:0];
    return c;
  endfunction

  function automatic logic [RND_W-1:0] rnd_next(input logic [RND_W-1:0] r);
    return {r[RND_W-2:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
  endfunction

endpackage

// File: rtl/cal_cell_cfg.sv
module cal_cell_cfg
  import cal_cell_pkg::*;
#(
  parameter logic [15:0] CFG_RST = 16'h00F0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [15:0] wdata,
  output cal_cfg_t    cfg
);

  logic unused_word_bits;
  assign unused_word_bits = ^{wdata[15:13], wdata[11]};

  always_ff @(posedge clk) begin
    if (rst)     cfg <= unpack_word(CFG_RST);
    else if (we) cfg <= unpack_word(wdata);
  end

endmodule

// File: rtl/cal_cell_pick.sv
module cal_cell_pick
  import cal_cell_pkg::*;
#(
  parameter int unsigned CELL_W    = 6,
  parameter int unsigned CELL_LO   = 5,
  parameter int unsigned CELL_HI   = 46,
  parameter int unsigned FIX_BASE  = 8,
  parameter int unsigned STEP_CODE = 48,
  parameter logic [RND_W-1:0] RND_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  cal_cfg_t          cfg,
  input  logic              req,
  output logic              accept,
  output logic [CELL_W-1:0] l1_cell,
  output logic              l1_chip,
  output logic [CELL_W-1:0] l2_cell,
  output logic              cell_valid
);

  // Codes below SPLIT land on the named chip at FIX_BASE upward;
  // codes SPLIT..LAST spill onto the other chip at CELL_LO upward.
  localparam int unsigned SPLIT = CELL_HI - FIX_BASE + 1;
  localparam int unsigned LAST  = SPLIT + (FIX_BASE - CELL_LO) - 1;

  localparam logic [CELL_W-1:0] C_LO    = CELL_W'(CELL_LO);
  localparam logic [CELL_W-1:0] C_HI    = CELL_W'(CELL_HI);
  localparam logic [CELL_W-1:0] C_BASE  = CELL_W'(FIX_BASE);
  localparam logic [CELL_W-1:0] C_SPLIT = CELL_W'(SPLIT);
  localparam logic [CELL_W-1:0] C_LAST  = CELL_W'(LAST);
  localparam logic [CELL_W-1:0] C_STEP  = CELL_W'(STEP_CODE);

  logic [CELL_W-1:0] step_q;
  logic              half_q;    // chip alternation state
  logic [RND_W-1:0]  rnd_q;

  logic [CELL_W-1:0] code;
  logic              code_fix;
  logic [CELL_W-1:0] map_cell;
  logic              map_other;

  logic [CELL_W-1:0] n_cell, n_l2;
  logic              n_chip, n_ok;
  logic              do_step, do_flip, do_rnd;

  assign code     = CELL_W'(cfg.code);
  assign code_fix = (code <= C_LAST);

  always_comb begin
    if (code < C_SPLIT) begin
      map_cell  = code + C_BASE;
      map_other = 1'b0;
    end else begin
      map_cell  = code - C_SPLIT + C_LO;
      map_other = 1'b1;
    end
  end

  always_comb begin
    n_cell  = '0;
    n_chip  = 1'b0;
    n_l2    = '0;
    n_ok    = 1'b0;
    do_step = 1'b0;
    do_flip = 1'b0;
    do_rnd  = 1'b0;
    if (cfg.l2_fix) begin
      if (code != '0 && code <= C_HI) begin
        n_ok = 1'b1;
        n_l2 = code;
        if (cfg.scan) begin
          n_cell  = step_q;
          n_chip  = rnd_q[0];
          do_step = 1'b1;
          do_rnd  = 1'b1;
        end else begin
          n_cell = C_LO;
          n_chip = cfg.chip;
        end
      end
    end else if (cfg.scan) begin
      if (cfg.chip) begin
        n_ok    = 1'b1;
        n_cell  = step_q;
        n_chip  = half_q;
        do_step = 1'b1;
        do_flip = (step_q == C_HI);
      end else if (code_fix) begin
        n_ok    = 1'b1;
        n_cell  = map_cell;
        n_chip  = map_other ^ half_q;
        do_flip = 1'b1;
      end
    end else if (code_fix) begin
      n_ok   = 1'b1;
      n_cell = map_cell;
      n_chip = map_other ^ cfg.chip;
    end else if (code >= C_STEP) begin
      n_ok    = 1'b1;
      n_cell  = step_q;
      n_chip  = cfg.chip;
      do_step = 1'b1;
    end
  end

  assign accept = req & n_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= C_LO;
      half_q <= 1'b0;
      rnd_q  <= RND_SEED;
    end else begin
      if (cfg_we) begin
        step_q <= C_LO;
        half_q <= 1'b0;
      end else if (accept) begin
        if (do_step) step_q <= (step_q == C_HI) ? C_LO : step_q + 1'b1;
        if (do_flip) half_q <= ~half_q;
      end
      if (accept && do_rnd) rnd_q <= rnd_next(rnd_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_cell    <= '0;
      l1_chip    <= 1'b0;
      l2_cell    <= '0;
      cell_valid <= 1'b0;
    end else if (req) begin
      l1_cell    <= n_cell;
      l1_chip    <= n_chip;
      l2_cell    <= n_l2;
      cell_valid <= n_ok;
    end
  end

endmodule

// File: rtl/cal_cell_strobe.sv
module cal_cell_strobe #(
  parameter int unsigned TRIG_DLY = 3,
  parameter int unsigned MAX_OFS  = 7,
  localparam int unsigned OFS_W   = $clog2(MAX_OFS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [OFS_W-1:0] ofs,
  output logic             trig_strobe,
  output logic             pulse_strobe
);

  // age[k] is high when an accepted request was sampled k edges ago.
  logic [MAX_OFS:0] age;
  logic [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0] ofs_sel;

  assign age[0] = fire;

  for (genvar k = 1; k <= MAX_OFS; k++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) age[k] <= 1'b0;
      else     age[k] <= age[k-1];
    end
  end

  assign ofs_sel = fire ? ofs : ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q        <= '0;
      trig_strobe  <= 1'b0;
      pulse_strobe <= 1'b0;
    end else begin
      if (fire) ofs_q <= ofs;
      trig_strobe  <= age[TRIG_DLY];
      pulse_strobe <= age[ofs_sel];
    end
  end

endmodule

// File: rtl/cal_cell_sequencer.sv
module cal_cell_sequencer
  import cal_cell_pkg::*;
#(
  parameter int unsigned CELL_W    = 6,
  parameter int unsigned CELL_LO   = 5,
  parameter int unsigned CELL_HI   = 46,
  parameter int unsigned FIX_BASE  = 8,
  parameter int unsigned STEP_CODE = 48,
  parameter int unsigned TRIG_DLY  = 3,
  parameter int unsigned MAX_OFS   = 7,
  parameter logic [15:0] CFG_RST   = 16'h00F0,
  parameter logic [15:0] RND_SEED  = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic              trig_req,
  output logic [CELL_W-1:0] l1_cell,
  output logic              l1_chip,
  output logic [CELL_W-1:0] l2_cell,
  output logic              cell_valid,
  output logic              trig_strobe,
  output logic              pulse_strobe
);

  localparam int unsigned OFS_W = $clog2(MAX_OFS + 1);

  cal_cfg_t         cfg;
  logic             accept;
  logic [OFS_W-1:0] ofs;

  // Skew code to pulser delay: lead codes 1..3, lag codes 7,4,5,6 for 1..4.
  function automatic logic [OFS_W-1:0] skew_to_ofs(input logic [2:0] s);
    int unsigned d;
    if (s < 3'd4)       d = TRIG_DLY - int'(s);
    else if (s == 3'd7) d = TRIG_DLY + 1;
    else                d = TRIG_DLY + int'(s) - 2;
    return OFS_W'(d);
  endfunction

  assign ofs = skew_to_ofs(cfg.skew);

  cal_cell_cfg #(.CFG_RST(CFG_RST)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  cal_cell_pick #(
    .CELL_W   (CELL_W),
    .CELL_LO  (CELL_LO),
    .CELL_HI  (CELL_HI),
    .FIX_BASE (FIX_BASE),
    .STEP_CODE(STEP_CODE),
    .RND_SEED (RND_SEED)
  ) u_pick (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg       (cfg),
    .req       (trig_req),
    .accept    (accept),
    .l1_cell   (l1_cell),
    .l1_chip   (l1_chip),
    .l2_cell   (l2_cell),
    .cell_valid(cell_valid)
  );

  cal_cell_strobe #(.TRIG_DLY(TRIG_DLY), .MAX_OFS(MAX_OFS)) u_strobe (
    .clk         (clk),
    .rst         (rst),
    .fire        (accept),
    .ofs         (ofs),
    .trig_strobe (trig_strobe),
    .pulse_strobe(pulse_strobe)
  );

endmodule

// File: rtl/cal_cell_chk.sv
module cal_cell_chk #(
  parameter int unsigned CELL_W  = 6,
  parameter int unsigned CELL_LO = 5,
  parameter int unsigned CELL_HI = 46
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_req,
  input logic [CELL_W-1:0] l1_cell,
  input logic              l1_chip,
  input logic [CELL_W-1:0] l2_cell,
  input logic              cell_valid,
  input logic              trig_strobe,
  input logic              pulse_strobe
);

  AST_CELL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cell_valid |-> (l1_cell >= CELL_W'(CELL_LO) && l1_cell <= CELL_W'(CELL_HI))); // R2

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cell_valid |-> (l1_cell == '0 && !l1_chip && l2_cell == '0)); // R3

  AST_L2_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (l2_cell != '0) |-> (cell_valid && l2_cell <= CELL_W'(CELL_HI))); // R7

  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    ($past(!trig_req) && $past(!rst)) |->
      ($stable(l1_cell) && $stable(l1_chip) && $stable(l2_cell) && $stable(cell_valid))); // R9

  AST_TRIG_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    trig_strobe |-> $past(trig_req, 4)); // R10

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trig_strobe |=> !trig_strobe); // R10

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulse_strobe |=> !pulse_strobe); // R11

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (trig_strobe || pulse_strobe) |-> cell_valid); // R12

endmodule

bind cal_cell_sequencer cal_cell_chk #(
  .CELL_W (CELL_W),
  .CELL_LO(CELL_LO),
  .CELL_HI(CELL_HI)
) u_cal_cell_chk (
  .clk         (clk),
  .rst         (rst),
  .trig_req    (trig_req),
  .l1_cell     (l1_cell),
  .l1_chip     (l1_chip),
  .l2_cell     (l2_cell),
  .cell_valid  (cell_valid),
  .trig_strobe (trig_strobe),
  .pulse_strobe(pulse_strobe)
);

// File: tb/test_cal_cell_sequencer.sv
module test_cal_cell_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        trig_req = 1'b0;
  logic [5:0]  l1_cell;
  logic        l1_chip;
  logic [5:0]  l2_cell;
  logic        cell_valid;
  logic        trig_strobe;
  logic        pulse_strobe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model of the sequencing state
  logic [15:0] cur_cfg = 16'h00F0;
  int          m_step  = 5;
  bit          m_half  = 1'b0;
  logic [15:0] m_rnd   = 16'hACE1;

  always #5 clk = ~clk;

  cal_cell_sequencer i_cal_cell_sequencer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig_req(trig_req), .l1_cell(l1_cell), .l1_chip(l1_chip),
    .l2_cell(l2_cell), .cell_valid(cell_valid),
    .trig_strobe(trig_strobe), .pulse_strobe(pulse_strobe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = w;
    m_step = 5;
    m_half = 1'b0;
  endtask

  function automatic int skew_delay(input int s);
    case (s)
      0: return 3;  1: return 2;  2: return 1;  3: return 0;
      4: return 5;  5: return 6;  6: return 7;  default: return 4;
    endcase
  endfunction

  task automatic next_step();
    m_step = (m_step == 46) ? 5 : m_step + 1;
  endtask

  // One request: predict, drive, check outputs and strobe timing.
  task automatic request(input string req);
    int code = int'(cur_cfg[5:0]);
    bit sel = cur_cfg[6];
    bit scn = cur_cfg[7];
    bit l2m = cur_cfg[12];
    bit ok = 0;
    int ecell = 0;
    int echip = 0;
    int el2 = 0;
    int fixcell = (code < 39) ? code + 8 : code - 34;
    int fixflip = (code < 39) ? 0 : 1;
    int pdel = skew_delay(int'(cur_cfg[10:8]));
    int tseen = 0, pseen = 0, tat = -1, pat = -1;

    if (l2m) begin
      if (code >= 1 && code <= 46) begin
        ok = 1; el2 = code;
        if (scn) begin
          ecell = m_step; echip = int'(m_rnd[0]);
          next_step();
          m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
        end else begin
          ecell = 5; echip = int'(sel);
        end
      end
    end else if (scn && sel) begin
      ok = 1; ecell = m_step; echip = int'(m_half);
      if (m_step == 46) m_half = ~m_half;
      next_step();
    end else if (scn) begin
      if (code <= 41) begin
        ok = 1; ecell = fixcell; echip = fixflip ^ int'(m_half);
        m_half = ~m_half;
      end
    end else if (code <= 41) begin
      ok = 1; ecell = fixcell; echip = fixflip ^ int'(sel);
    end else if (code >= 48) begin
      ok = 1; ecell = m_step; echip = int'(sel);
      next_step();
    end

    @(negedge clk);
    trig_req = 1'b1;
    @(negedge clk);
    trig_req = 1'b0;
    check(req, "cell_valid", int'(cell_valid), int'(ok));
    check(req, "l1_cell", int'(l1_cell), ecell);
    check(req, "l1_chip", int'(l1_chip), echip);
    check(req, "l2_cell", int'(l2_cell), el2);
    for (int k = 0; k <= 10; k++) begin
      if (k > 0) @(negedge clk);
      if (trig_strobe)  begin tseen++; tat = k; end
      if (pulse_strobe) begin pseen++; pat = k; end
    end
    // R10 R11 R12: strobe counts and arrival cycles
    check(ok ? "R10" : "R12", "trig count", tseen, ok ? 1 : 0);
    check(ok ? "R11" : "R12", "pulse count", pseen, ok ? 1 : 0);
    if (ok) begin
      check("R10", "trig cycle", tat, 3);
      check("R11", "pulse cycle", pat, pdel);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "l1_cell", int'(l1_cell), 0);
    check("R1", "l1_chip", int'(l1_chip), 0);
    check("R1", "l2_cell", int'(l2_cell), 0);
    check("R1", "cell_valid", int'(cell_valid), 0);
    check("R1", "trig_strobe", int'(trig_strobe), 0);
    check("R1", "pulse_strobe", int'(pulse_strobe), 0);
    // R1 default word 0x00F0: full scan from cell 5 on upper chip
    request("R1");
    request("R1");

    // R2 / R3 / R4: every code, plain mode, both chips
    for (int c = 0; c < 64; c++) begin
      write_cfg(16'(c) | ((c % 2 == 1) ? 16'h0040 : 16'h0000));
      request((c <= 41) ? "R2" : (c <= 47) ? "R3" : "R4");
    end
    // R4: long stepping run across two wraps, then restart on write
    write_cfg(16'h0035);
    for (int i = 0; i < 90; i++) request("R4");
    write_cfg(16'h0078 & 16'h003F | 16'h0040);
    for (int i = 0; i < 5; i++) request("R4");
    write_cfg(16'h007F);
    request("R4");

    // R5: coded cell with alternating chip, every code
    for (int c = 0; c < 64; c++) begin
      write_cfg(16'h0080 | 16'(c));
      for (int i = 0; i < 3; i++) request("R5");
    end
    // R6: full scan, code ignored, two chip turnovers, then restart
    write_cfg(16'h00D5);
    for (int i = 0; i < 90; i++) request("R6");
    write_cfg(16'h00C0);
    request("R6");

    // R7: pinned L2 cell, every code, both chips
    for (int c = 0; c < 64; c++) begin
      write_cfg(16'h1000 | 16'(c) | ((c % 3 == 0) ? 16'h0040 : 16'h0000));
      request("R7");
    end
    // R8: pinned L2 with stepping L1 and pseudo-random chip
    write_cfg(16'h1080 | 16'd17);
    for (int i = 0; i < 50; i++) request("R8");
    write_cfg(16'h10C0 | 16'd46);
    for (int i = 0; i < 10; i++) request("R8");

    // R11: all eight skews, plus ignored reserved bits
    for (int s = 0; s < 8; s++) begin
      write_cfg(16'hE800 | (16'(s) << 8) | 16'd12);
      request("R11");
    end

    // R9: outputs hold while no request arrives, even across a write
    write_cfg(16'h0003);
    request("R9");
    write_cfg(16'h002B);
    repeat (4) @(negedge clk);
    check("R9", "held l1_cell", int'(l1_cell), 11);
    check("R9", "held cell_valid", int'(cell_valid), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule